// File: doc/BRIEF.md
# Register-Mapped SPI Flash Command Engine

This block is a byte-wide register file in front of a mode-0 SPI master. Software loads a command opcode, a packed byte count and up to eight payload bytes, then sets a start bit. The engine lowers chip select and shifts out the opcode. It then sends the payload bytes and clocks in the response bytes. It raises chip select again one SPI clock period after the last bit.

The opcode has its own register and is never held in the shared buffer. Payload and response bytes share one eight-entry buffer behind a single data port. A software-visible pointer selects the entry for that port and can be rewound. Response bytes land just behind the payload bytes. To collect them, software rewinds the pointer, reads past the payload count, and then reads the response.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, cs_n is high, sclk is low, mosi is low, the busy flag (register 3 bit 7) reads 0 and the pointer (register 0xD) reads 0.
- R2: The byte written to register 0 is the first byte sent in every frame, whatever the buffer holds.
- R3: Register 1 holds the response count in bits [7:4] and the payload count in bits [3:0]. With a payload count N > 0, the frame has 1 + N + response-count bytes, and payload byte k is taken from buffer entry k.
- R4: With a payload count N > 0, the byte clocked in during response slot j is stored in buffer entry N + j.
- R5: With a payload count of 0, the response count includes the opcode slot. The frame is response-count bytes long (at least one). The byte clocked in during slot k is stored in entry k, so entry 0 holds what was sampled during the opcode.
- R6: Writing register 2 with bit 0 set starts a frame. Register 2 bit 0 and register 3 bit 7 read 1 from the cycle after the start until the frame has ended, then read 0.
- R7: Writing register 2 with bit 4 set returns the pointer to 0. The pointer reads back in bits [2:0] of register 0xD.
- R8: Each read or write of register 0xC accesses the buffer entry at the pointer and then advances the pointer by one. The pointer wraps from 7 to 0.
- R9: While busy, writes to registers 0, 1 and 0xC have no effect, and a write to 0xC does not advance the pointer.
- R10: The SPI clock is SPI mode 0 at clk/DIV. It idles low, data goes out MSB first, mosi changes only while sclk is low, and cs_n is low for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances pointer on 0xC) |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
A pointer that is off by one would show up on the very next data-port read: every byte would come back from the wrong entry. A slot counter that is off would misplace the response bytes. It would also change how many bytes the bench's flash model sees in the frame, and that shows up when the frame ends. A busy flag that clears early would let a write made during the frame corrupt the opcode, the count or the pointer. That corruption is visible on the readback right after the frame. A shifter that is out of phase would turn every payload byte the flash model receives into a wrong value within the first byte.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [1:0] {ENG_IDLE, ENG_RUN, ENG_TAIL} eng_state_t;

  // Bytes in one frame; with no payload the response count covers the opcode slot.
  function automatic logic [4:0] frame_len(input logic [3:0] tx, input logic [3:0] rx);
    if (tx == 4'd0) return (rx == 4'd0) ? 5'd1 : {1'b0, rx};
    return 5'd1 + {1'b0, tx} + {1'b0, rx};
  endfunction

  // Whether the byte sampled during a slot is kept in the buffer.
  function automatic logic rx_keep(input logic [3:0] tx, input logic [4:0] slot);
    return (tx == 4'd0) || (slot > {1'b0, tx});
  endfunction

  // Buffer entry for the byte sampled during a slot.
  function automatic logic [4:0] rx_index(input logic [3:0] tx, input logic [4:0] slot);
    return (tx == 4'd0) ? slot : slot - 5'd1;
  endfunction

endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdata_a,
  output logic [7:0]    rdata_b
);
  logic [7:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[i] <= 8'h00;
      else if (we && waddr == AW'(i)) mem[i] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [4:0] len,
  input  logic [7:0] first_byte,
  input  logic [7:0] tx_next,
  output logic [4:0] slot,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       busy,
  output logic       sclk,
  output logic       cs_n,
  output logic       mosi,
  input  logic       miso
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW = $clog2(DIV) + 1;

  eng_state_t   state;
  logic [CW-1:0] div_cnt;
  logic [2:0]   bit_cnt;
  logic [7:0]   tx_sh, rx_sh;
  logic         half_tick, tail_done;

  assign half_tick = (state == ENG_RUN) && (div_cnt == CW'(HALF - 1));
  assign tail_done = (state == ENG_TAIL) && (div_cnt == CW'(DIV - 1));
  assign byte_done = half_tick && sclk && (bit_cnt == 3'd0);
  assign rx_byte   = rx_sh;
  assign busy      = (state != ENG_IDLE);
  assign cs_n      = (state == ENG_IDLE);
  assign mosi      = (state == ENG_RUN) ? tx_sh[7] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ENG_IDLE; div_cnt <= '0; bit_cnt <= 3'd7;
      tx_sh <= 8'h00; rx_sh <= 8'h00; sclk <= 1'b0; slot <= 5'd0;
    end else begin
      case (state)
        ENG_IDLE: if (start) begin
          state <= ENG_RUN; div_cnt <= '0; bit_cnt <= 3'd7;
          tx_sh <= first_byte; sclk <= 1'b0; slot <= 5'd0;
        end
        ENG_RUN: begin
          if (half_tick) begin
            div_cnt <= '0;
            sclk    <= ~sclk;
            if (!sclk) rx_sh <= {rx_sh[6:0], miso};
            else if (bit_cnt == 3'd0) begin
              bit_cnt <= 3'd7;
              slot    <= slot + 5'd1;
              tx_sh   <= tx_next;
              if (slot + 5'd1 == len) state <= ENG_TAIL;
            end else begin
              bit_cnt <= bit_cnt - 3'd1;
              tx_sh   <= {tx_sh[6:0], 1'b0};
            end
          end else div_cnt <= div_cnt + CW'(1);
        end
        ENG_TAIL: begin
          if (tail_done) begin state <= ENG_IDLE; div_cnt <= '0; end
          else div_cnt <= div_cnt + CW'(1);
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DIV   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       sclk,
  output logic       cs_n,
  output logic       mosi,
  input  logic       miso
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [3:0] A_OPC = 4'h0, A_CNT = 4'h1, A_CTL = 4'h2,
                         A_STS = 4'h3, A_DAT = 4'hC, A_PTR = 4'hD;

  logic [7:0]    opcode_q, count_q;
  logic [AW-1:0] ptr;
  logic          busy, start_evt, ptr_rst_evt, fifo_wr, fifo_rd, fifo_acc;
  logic          opcode_wr_try, eng_store, byte_done;
  logic [4:0]    slot, next_slot, store_idx;
  logic [7:0]    rx_byte, port_rdata, eng_rdata, tx_next;
  logic [3:0]    tx_cnt, rx_cnt;

  assign tx_cnt        = count_q[3:0];
  assign rx_cnt        = count_q[7:4];
  assign opcode_wr_try = reg_wr && (reg_addr == A_OPC);
  assign start_evt     = reg_wr && (reg_addr == A_CTL) && reg_wdata[0] && !busy;
  assign ptr_rst_evt   = reg_wr && (reg_addr == A_CTL) && reg_wdata[4];
  assign fifo_wr       = reg_wr && (reg_addr == A_DAT) && !busy;
  assign fifo_rd       = reg_rd && (reg_addr == A_DAT);
  assign fifo_acc      = fifo_wr || fifo_rd;
  assign eng_store     = byte_done && rx_keep(tx_cnt, slot);
  assign store_idx     = rx_index(tx_cnt, slot);
  assign next_slot     = slot + 5'd1;
  assign tx_next       = (next_slot <= {1'b0, tx_cnt}) ? eng_rdata : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_q <= 8'h00; count_q <= 8'h00; ptr <= '0;
    end else begin
      if (opcode_wr_try && !busy) opcode_q <= reg_wdata;
      if (reg_wr && reg_addr == A_CNT && !busy) count_q <= reg_wdata;
      if (ptr_rst_evt) ptr <= '0;
      else if (fifo_acc) ptr <= ptr + AW'(1);
    end
  end

  spi_cmd_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .we(eng_store || fifo_wr),
    .waddr(eng_store ? store_idx[AW-1:0] : ptr),
    .wdata(eng_store ? rx_byte : reg_wdata),
    .raddr_a(ptr), .raddr_b(slot[AW-1:0]),
    .rdata_a(port_rdata), .rdata_b(eng_rdata)
  );

  spi_cmd_shifter #(.DIV(DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_evt),
    .len(frame_len(tx_cnt, rx_cnt)), .first_byte(opcode_q), .tx_next(tx_next),
    .slot(slot), .byte_done(byte_done), .rx_byte(rx_byte), .busy(busy),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  always_comb begin
    case (reg_addr)
      A_OPC:   reg_rdata = opcode_q;
      A_CNT:   reg_rdata = count_q;
      A_CTL:   reg_rdata = {7'd0, busy};
      A_STS:   reg_rdata = {busy, 7'd0};
      A_DAT:   reg_rdata = port_rdata;
      A_PTR:   reg_rdata = 8'(ptr);
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int unsigned AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          cs_n,
  input logic          sclk,
  input logic          mosi,
  input logic          start_evt,
  input logic          ptr_rst_evt,
  input logic          fifo_acc,
  input logic          opcode_wr_try,
  input logic [AW-1:0] ptr,
  input logic [7:0]    opcode_q
);
  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy && !cs_n);
  assert_ptr_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rst_evt |=> ptr == '0);
  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_acc && !ptr_rst_evt |=> ptr == AW'($past(ptr) + 1'b1));
  assert_opcode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && opcode_wr_try |=> $stable(opcode_q));
  assert_idle_clock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  assert_mosi_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sclk && $past(sclk) |-> $stable(mosi));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
  .start_evt(start_evt), .ptr_rst_evt(ptr_rst_evt), .fifo_acc(fifo_acc),
  .opcode_wr_try(opcode_wr_try), .ptr(ptr), .opcode_q(opcode_q)
);

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, miso = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic sclk, cs_n, mosi;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  spi_cmd_engine u_spi_cmd_engine (.*);

  // Flash model: answers slot k with 8'hA0 + k, records what it receives.
  logic [7:0] got [16];
  int nb = 0, bc = 0;
  logic [7:0] sh = 8'h00;
  function automatic logic [7:0] resp(input int k); return 8'hA0 + 8'(k); endfunction
  always @(negedge cs_n) begin nb = 0; bc = 0; miso = resp(0)[7]; end
  always @(posedge sclk) begin
    sh = {sh[6:0], mosi}; bc = bc + 1;
    if (bc == 8) begin if (nb < 16) got[nb] = sh; nb = nb + 1; bc = 0; end
  end
  always @(negedge sclk) miso = resp(nb)[7 - bc];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d, input bit pop = 1'b1);
    @(negedge clk); reg_rd = pop; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    do rd(4'h3, s); while (s[7]);
  endtask

  // {opcode, payload count, response count}
  localparam logic [15:0] VEC [6] = '{16'h0334, 16'h9F04, 16'h0502,
                                      16'h0271, 16'h0B17, 16'h0620};

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !mosi, "R1 pins", {cs_n, sclk, mosi}, 3'b100);
    rst_n = 1'b1;
    rd(4'h3, v); chk(v == 8'h00, "R1 busy", v, 0);
    rd(4'hD, v); chk(v == 8'h00, "R1 ptr", v, 0);

    for (int i = 0; i < 6; i++) begin
      logic [7:0] op; int tx, rx, len;
      op = VEC[i][15:8]; tx = VEC[i][7:4]; rx = VEC[i][3:0];
      len = (tx == 0) ? ((rx == 0) ? 1 : rx) : 1 + tx + rx;
      wr(4'h0, op); wr(4'h1, {4'(rx), 4'(tx)}); wr(4'h2, 8'h10);
      for (int k = 0; k < tx; k++) wr(4'hC, 8'h10 + 8'(k) + 8'(i));
      wr(4'h2, 8'h10);
      wr(4'h2, 8'h01);
      rd(4'h2, v); chk(v[0], "R6 ctrl bit reads 1", v, 1);
      wait_idle();
      rd(4'h2, v); chk(v[0] == 1'b0, "R6 ctrl bit clears", v, 0);
      chk(nb == len, "R3 frame length", nb, len);
      chk(got[0] == op, "R2 opcode first", got[0], op);
      for (int k = 0; k < tx; k++)
        chk(got[1+k] == 8'h10 + 8'(k) + 8'(i), "R3/R10 payload byte", got[1+k], 8'h10 + k + i);
      wr(4'h2, 8'h10);
      rd(4'hD, v); chk(v == 8'h00, "R7 rewind", v, 0);
      for (int k = 0; k < tx + rx && k < 8; k++) begin
        rd(4'hC, v);
        if (tx == 0) chk(v == resp(k), "R5 entry k", v, resp(k));
        else if (k >= tx) chk(v == resp(k + 1), "R4 response entry", v, resp(k + 1));
      end
    end

    // R9: writes during a frame are dropped.
    wr(4'h0, 8'h9F); wr(4'h1, 8'h20); wr(4'h2, 8'h10); wr(4'h2, 8'h01);
    wr(4'h0, 8'h55); wr(4'h1, 8'h11); wr(4'hC, 8'hEE);
    wait_idle();
    rd(4'h0, v); chk(v == 8'h9F, "R9 opcode kept", v, 8'h9F);
    rd(4'h1, v); chk(v == 8'h20, "R9 count kept", v, 8'h20);
    rd(4'hD, v); chk(v == 8'h00, "R9 pointer kept", v, 0);
    rd(4'hC, v); chk(v == resp(0), "R9 data not written", v, resp(0));

    // R8: pointer wraps after eight accesses.
    wr(4'h2, 8'h10);
    for (int k = 0; k < 8; k++) wr(4'hC, 8'h30 + 8'(k));
    rd(4'hD, v); chk(v == 8'h00, "R8 wrap to 0", v, 0);
    wr(4'hC, 8'h99);
    rd(4'hD, v); chk(v == 8'h01, "R8 advance", v, 1);
    wr(4'h2, 8'h10);
    rd(4'hC, v); chk(v == 8'h99, "R8 entry 0 overwritten", v, 8'h99);
    rd(4'hC, v); chk(v == 8'h31, "R8 entry 1", v, 8'h31);
    chk(cs_n && !sclk, "R10 idle pins", {cs_n, sclk}, 2'b10);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule